// File: doc/BRIEF.md
# Registered Twelve-to-Twenty-Four Bit Bus Exchanger

This block joins one 12-bit port (A) to a pair of 12-bit ports (lower lane and upper lane) that together form a 24-bit word on the wide side. Going from narrow to wide, each lane has its own storage register with an active-low capture enable. Pulsing the lower enable and then the upper enable on successive cycles places two consecutive A words side by side as one 24-bit word. Going from wide to narrow, a select input picks one lane, and a single register that loads on every clock edge drives the A output. No data path inverts.

Every control input passes through a register before it acts: the two capture enables, the select and the three active-low output enables. A control sampled at one rising edge acts at the following edge. Each port brings out its data and an active-high drive-enable in place of a three-state pin. The drive-enables are registered, so they are only defined after the first clock edge. A synchronous active-high reset clears the data registers and turns every drive-enable off.

Top module: `wpx_exchanger`

## Requirements
- R1: If the lower capture enable is sampled low at edge N and the upper capture enable at edge N+1, the 24-bit word {upper_out, lower_out} equals {A at edge N+2, A at edge N+1}. The lower lane occupies bits 11:0 and the upper lane bits 23:12.
- R2: If `cap_lo_n` is sampled low at edge N, `lo_out` equals the `a_in` value present at edge N+1, unchanged and not inverted, from edge N+1 onward.
- R3: If `cap_hi_n` is sampled low at edge N, `hi_out` equals the `a_in` value present at edge N+1 from edge N+1 onward.
- R4: If a capture enable is sampled high at edge N, its lane output keeps its value through edge N+1, whatever `a_in` does.
- R5: If `pick_hi` is sampled 1 at edge N, `a_out` equals the `hi_in` value present at edge N+1.
- R6: If `pick_hi` is sampled 0 at edge N, `a_out` equals the `lo_in` value present at edge N+1. The A register loads on every edge, so `a_out` follows the lower input from edge to edge.
- R7: An output enable (`oe_a_n`, `oe_lo_n`, `oe_hi_n`) sampled at edge N sets its drive-enable output at edge N+1: low turns the drive on (1) and high turns it off (0).
- R8: At an edge where `rst` is 1, all three data outputs become 0 and all three drive-enables become 0. At the first edge after reset the drive-enables stay 0 and no lane captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 12 | Narrow-side data coming into the block |
| lo_in | input | 12 | Lower-lane wide-side data coming in |
| hi_in | input | 12 | Upper-lane wide-side data coming in |
| cap_lo_n | input | 1 | Active-low capture enable for the lower lane (registered) |
| cap_hi_n | input | 1 | Active-low capture enable for the upper lane (registered) |
| pick_hi | input | 1 | Wide-to-narrow select: 0 picks the lower lane, 1 the upper (registered) |
| oe_a_n | input | 1 | Active-low output enable for the A port (registered) |
| oe_lo_n | input | 1 | Active-low output enable for the lower lane (registered) |
| oe_hi_n | input | 1 | Active-low output enable for the upper lane (registered) |
| a_out | output | 12 | Narrow-side data from the wide-to-narrow register |
| a_drive | output | 1 | Drive-enable for the A port |
| lo_out | output | 12 | Lower-lane captured word |
| lo_drive | output | 1 | Drive-enable for the lower lane |
| hi_out | output | 12 | Upper-lane captured word |
| hi_drive | output | 1 | Drive-enable for the upper lane |

## Verification
Staggered single-cycle capture pulses with distinct words check that each lane takes the word from the edge after its enable. The same pulses also check that the 24-bit word comes out in the right half order. Simultaneous enables, walking-one words and all-ones/alternating words show up a swapped lane, a stuck bit or an inverted path. Select stimulus changes the lane inputs every cycle while the select is held and while it toggles. This separates a one-edge control delay from a zero-edge or two-edge one, and a mux that loads every edge from one that holds. Output enables are toggled one at a time and a reset is applied in mid-run; a long pseudo-random run then mixes all the controls.

// File: rtl/wpx_pkg.sv
package wpx_pkg;

    localparam int unsigned NUM_LANES = 2;
    localparam int unsigned NUM_PORTS = NUM_LANES + 1;

    // lane index: 0 = lower lane, 1 = upper lane
    typedef enum logic {
        PICK_LO = 1'b0,
        PICK_HI = 1'b1
    } pick_e;

    // output-enable slot order inside the control word
    typedef enum int unsigned {
        SLOT_A  = 0,
        SLOT_LO = 1,
        SLOT_HI = 2
    } slot_e;

    typedef struct packed {
        logic [NUM_LANES-1:0] cap_n;
        pick_e                pick;
        logic [NUM_PORTS-1:0] oe_n;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{cap_n: '1, pick: PICK_LO, oe_n: '1};

    function automatic logic [NUM_PORTS-1:0] drive_of(input logic [NUM_PORTS-1:0] oe_n);
        return ~oe_n;
    endfunction

endpackage

// File: rtl/wpx_ctrl_stage.sv
module wpx_ctrl_stage
    import wpx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl_d,
    output ctrl_t ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_IDLE;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/wpx_lane_reg.sv
module wpx_lane_reg #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/wpx_return_reg.sv
module wpx_return_reg #(
    parameter int unsigned W     = 12,
    parameter int unsigned LANES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [IDX_W-1:0]            idx,
    input  logic [LANES-1:0][W-1:0]     lanes,
    output logic [W-1:0]                q
);

    localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [W-1:0] chosen;

    always_comb begin
        chosen = '0;
        for (int unsigned l = 0; l < LANES; l++) begin
            if (idx == IDX_W'(l)) begin
                chosen = lanes[l];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= chosen;
        end
    end

endmodule

// File: rtl/wpx_drive_stage.sv
module wpx_drive_stage #(
    parameter int unsigned PORTS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PORTS-1:0] en_d,
    output logic [PORTS-1:0] en_q
);

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[p] <= 1'b0;
            end else begin
                en_q[p] <= en_d[p];
            end
        end
    end

endmodule

// File: rtl/wpx_exchanger.sv
module wpx_exchanger
    import wpx_pkg::*;
#(
    parameter int unsigned WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] lo_in,
    input  logic [WIDTH-1:0] hi_in,
    input  logic             cap_lo_n,
    input  logic             cap_hi_n,
    input  logic             pick_hi,
    input  logic             oe_a_n,
    input  logic             oe_lo_n,
    input  logic             oe_hi_n,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drive,
    output logic [WIDTH-1:0] lo_out,
    output logic             lo_drive,
    output logic [WIDTH-1:0] hi_out,
    output logic             hi_drive
);

    ctrl_t ctrl_d;
    ctrl_t ctrl_q;

    logic [NUM_LANES-1:0][WIDTH-1:0] wide_in;
    logic [NUM_LANES-1:0][WIDTH-1:0] lane_q;
    logic [NUM_LANES-1:0]            lane_load;
    logic [NUM_PORTS-1:0]            drive_q;

    always_comb begin
        ctrl_d               = CTRL_IDLE;
        ctrl_d.cap_n[0]      = cap_lo_n;
        ctrl_d.cap_n[1]      = cap_hi_n;
        ctrl_d.pick          = pick_hi ? PICK_HI : PICK_LO;
        ctrl_d.oe_n[SLOT_A]  = oe_a_n;
        ctrl_d.oe_n[SLOT_LO] = oe_lo_n;
        ctrl_d.oe_n[SLOT_HI] = oe_hi_n;
    end

    wpx_ctrl_stage u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .ctrl_d (ctrl_d),
        .ctrl_q (ctrl_q)
    );

    assign wide_in[0] = lo_in;
    assign wide_in[1] = hi_in;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign lane_load[l] = ~ctrl_q.cap_n[l];

        wpx_lane_reg #(.W(WIDTH)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .load (lane_load[l]),
            .d    (a_in),
            .q    (lane_q[l])
        );
    end

    wpx_return_reg #(.W(WIDTH), .LANES(NUM_LANES)) u_ret (
        .clk   (clk),
        .rst   (rst),
        .idx   (ctrl_q.pick),
        .lanes (wide_in),
        .q     (a_out)
    );

    wpx_drive_stage #(.PORTS(NUM_PORTS)) u_drv (
        .clk  (clk),
        .rst  (rst),
        .en_d (drive_of(ctrl_q.oe_n)),
        .en_q (drive_q)
    );

    assign lo_out   = lane_q[0];
    assign hi_out   = lane_q[1];
    assign a_drive  = drive_q[SLOT_A];
    assign lo_drive = drive_q[SLOT_LO];
    assign hi_drive = drive_q[SLOT_HI];

endmodule

// File: rtl/wpx_exchanger_chk.sv
module wpx_exchanger_chk #(
    parameter int unsigned WIDTH = 12
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] lo_in,
    input logic [WIDTH-1:0] hi_in,
    input logic             cap_lo_n,
    input logic             cap_hi_n,
    input logic             pick_hi,
    input logic             oe_a_n,
    input logic             oe_lo_n,
    input logic             oe_hi_n,
    input logic [WIDTH-1:0] a_out,
    input logic             a_drive,
    input logic [WIDTH-1:0] lo_out,
    input logic             lo_drive,
    input logic [WIDTH-1:0] hi_out,
    input logic             hi_drive
);

    assert_cap_lo_R2: assert property (@(posedge clk) disable iff (rst)
        !cap_lo_n |=> ##1 (lo_out == $past(a_in)));

    assert_cap_hi_R3: assert property (@(posedge clk) disable iff (rst)
        !cap_hi_n |=> ##1 (hi_out == $past(a_in)));

    assert_hold_lo_R4: assert property (@(posedge clk) disable iff (rst)
        cap_lo_n |=> ##1 $stable(lo_out));

    assert_hold_hi_R4: assert property (@(posedge clk) disable iff (rst)
        cap_hi_n |=> ##1 $stable(hi_out));

    assert_pick_hi_R5: assert property (@(posedge clk) disable iff (rst)
        pick_hi |=> ##1 (a_out == $past(hi_in)));

    assert_pick_lo_R6: assert property (@(posedge clk) disable iff (rst)
        !pick_hi |=> ##1 (a_out == $past(lo_in)));

    assert_a_on_R7: assert property (@(posedge clk) disable iff (rst)
        !oe_a_n |=> ##1 a_drive);

    assert_a_off_R7: assert property (@(posedge clk) disable iff (rst)
        oe_a_n |=> ##1 !a_drive);

    assert_lo_on_R7: assert property (@(posedge clk) disable iff (rst)
        !oe_lo_n |=> ##1 lo_drive);

    assert_hi_off_R7: assert property (@(posedge clk) disable iff (rst)
        oe_hi_n |=> ##1 !hi_drive);

    assert_reset_R8: assert property (@(posedge clk)
        rst |=> (!a_drive && !lo_drive && !hi_drive &&
                 a_out == '0 && lo_out == '0 && hi_out == '0));

endmodule

bind wpx_exchanger wpx_exchanger_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .a_in     (a_in),
    .lo_in    (lo_in),
    .hi_in    (hi_in),
    .cap_lo_n (cap_lo_n),
    .cap_hi_n (cap_hi_n),
    .pick_hi  (pick_hi),
    .oe_a_n   (oe_a_n),
    .oe_lo_n  (oe_lo_n),
    .oe_hi_n  (oe_hi_n),
    .a_out    (a_out),
    .a_drive  (a_drive),
    .lo_out   (lo_out),
    .lo_drive (lo_drive),
    .hi_out   (hi_out),
    .hi_drive (hi_drive)
);

// File: tb/wpx_exchanger_test.sv
`timescale 1ns/1ps
module wpx_exchanger_test;

    localparam int W = 12;
    localparam int WATCHDOG_CYCLES = 20000;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, lo_in, hi_in;
    logic         cap_lo_n, cap_hi_n, pick_hi, oe_a_n, oe_lo_n, oe_hi_n;
    logic [W-1:0] a_out, lo_out, hi_out;
    logic         a_drive, lo_drive, hi_drive;

    always #5 clk = ~clk;

    wpx_exchanger #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .a_in(a_in), .lo_in(lo_in), .hi_in(hi_in),
        .cap_lo_n(cap_lo_n), .cap_hi_n(cap_hi_n), .pick_hi(pick_hi),
        .oe_a_n(oe_a_n), .oe_lo_n(oe_lo_n), .oe_hi_n(oe_hi_n),
        .a_out(a_out), .a_drive(a_drive), .lo_out(lo_out), .lo_drive(lo_drive),
        .hi_out(hi_out), .hi_drive(hi_drive)
    );

    typedef struct {
        logic         rst;
        logic         lo_cap, hi_cap, sel;
        logic [W-1:0] lo, hi, a;
        logic         da, dl, dh;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   fails = 0;
    bit   done  = 0;

    // requirement-level model of the registered controls and lane contents
    logic         m_c1, m_c2, m_sel, m_oa, m_ol, m_oh;
    logic [W-1:0] m_lo, m_hi;

    task automatic chk(string tag, string nm, logic [23:0] act, logic [23:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic [W-1:0] a, input logic [W-1:0] lo,
                        input logic [W-1:0] hi, input logic c1n, input logic c2n,
                        input logic s, input logic oa, input logic ol, input logic oh);
        exp_t e;
        @(negedge clk);
        rst = r; a_in = a; lo_in = lo; hi_in = hi;
        cap_lo_n = c1n; cap_hi_n = c2n; pick_hi = s;
        oe_a_n = oa; oe_lo_n = ol; oe_hi_n = oh;
        e.rst = r;
        if (r) begin
            m_lo = '0; m_hi = '0;
            e.a = '0; e.da = 0; e.dl = 0; e.dh = 0;
            e.lo_cap = 0; e.hi_cap = 0; e.sel = 0;
            m_c1 = 1; m_c2 = 1; m_sel = 0; m_oa = 1; m_ol = 1; m_oh = 1;
        end else begin
            e.lo_cap = !m_c1; e.hi_cap = !m_c2; e.sel = m_sel;
            if (!m_c1) m_lo = a;
            if (!m_c2) m_hi = a;
            e.a  = m_sel ? hi : lo;
            e.da = !m_oa; e.dl = !m_ol; e.dh = !m_oh;
            m_c1 = c1n; m_c2 = c2n; m_sel = s; m_oa = oa; m_ol = ol; m_oh = oh;
        end
        e.lo = m_lo; e.hi = m_hi;
        q.push_back(e);
    endtask

    // monitor: compares each expected item just after the edge it belongs to
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (e.rst) begin
                chk("R8", "lo_out",   24'(lo_out),   24'(e.lo));
                chk("R8", "hi_out",   24'(hi_out),   24'(e.hi));
                chk("R8", "a_out",    24'(a_out),    24'(e.a));
                chk("R8", "a_drive",  24'(a_drive),  24'(e.da));
                chk("R8", "lo_drive", 24'(lo_drive), 24'(e.dl));
                chk("R8", "hi_drive", 24'(hi_drive), 24'(e.dh));
            end else begin
                chk(e.lo_cap ? "R2" : "R4", "lo_out", 24'(lo_out), 24'(e.lo));
                chk(e.hi_cap ? "R3" : "R4", "hi_out", 24'(hi_out), 24'(e.hi));
                chk("R1", "wide_word", {hi_out, lo_out}, {e.hi, e.lo});
                chk(e.sel ? "R5" : "R6", "a_out", 24'(a_out), 24'(e.a));
                chk("R7", "a_drive",  24'(a_drive),  24'(e.da));
                chk("R7", "lo_drive", 24'(lo_drive), 24'(e.dl));
                chk("R7", "hi_drive", 24'(hi_drive), 24'(e.dh));
            end
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // R8: reset with every enable asserted must still leave drives off
        step(1, 12'hFFF, 12'hFFF, 12'hFFF, 0, 0, 1, 0, 0, 0);
        step(1, 12'h0F0, 12'h111, 12'h222, 0, 0, 0, 0, 0, 0);
        step(0, 12'h333, 12'h444, 12'h555, 1, 1, 0, 1, 1, 1);
        // R1/R2/R3: staggered capture of two words
        step(0, 12'h123, 12'h001, 12'h002, 0, 1, 0, 1, 1, 1);
        step(0, 12'hABC, 12'h003, 12'h004, 1, 0, 0, 1, 1, 1);
        step(0, 12'hDEF, 12'h005, 12'h006, 1, 1, 0, 1, 1, 1);
        // R4: A keeps moving, enables high
        for (int i = 0; i < 4; i++) step(0, 12'(i * 12'h247), 12'h7, 12'h8, 1, 1, 0, 1, 1, 1);
        // R1: all-ones then alternating words
        step(0, 12'hFFF, 0, 0, 0, 1, 0, 1, 1, 1);
        step(0, 12'hAAA, 0, 0, 1, 0, 0, 1, 1, 1);
        step(0, 12'h555, 0, 0, 1, 1, 0, 1, 1, 1);
        // R6: select low, lower input changes every cycle
        for (int i = 0; i < 4; i++) step(0, 0, 12'(12'h101 << i), 12'hF0F, 1, 1, 0, 1, 1, 1);
        // R5: select high, then toggling select
        for (int i = 0; i < 4; i++) step(0, 0, 12'h0A0, 12'(12'h011 << i), 1, 1, 1, 1, 1, 1);
        for (int i = 0; i < 6; i++) step(0, 0, 12'(i + 1), 12'(12'h800 | i), 1, 1, i[0], 1, 1, 1);
        // R7: each output enable alone, then all together
        step(0, 0, 0, 0, 1, 1, 0, 0, 1, 1);
        step(0, 0, 0, 0, 1, 1, 0, 1, 0, 1);
        step(0, 0, 0, 0, 1, 1, 0, 1, 1, 0);
        step(0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 1, 0, 1, 1, 1);
        // R2/R3: both enables low together, walking one on A
        for (int i = 0; i < W; i++) step(0, 12'(1 << i), 0, 0, 0, 0, 0, 0, 0, 0);
        // R8: reset in mid-run, then R7 first edge after reset
        step(1, 12'h777, 1, 2, 0, 0, 1, 0, 0, 0);
        step(0, 12'h666, 3, 4, 0, 1, 1, 0, 0, 0);
        step(0, 12'h999, 5, 6, 1, 1, 0, 0, 0, 0);
        // mixed pseudo-random run
        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            step(0, 12'($urandom), 12'($urandom), 12'($urandom),
                 rv[0], rv[1], rv[2], rv[3], rv[4], rv[5]);
        end
        step(0, 0, 0, 0, 1, 1, 0, 1, 1, 1);
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule